// File: doc/BRIEF.md
# Line-Aligned Range Maintenance Splitter

This sequencer turns one cache maintenance request, a byte range given as a start and an end address plus an operation code, into a series of commands for a maintenance queue. It widens the range to whole cache lines at both ends. It then cuts the widened range into chunks that never exceed a per-level limit, and closes every request with a sync command. When the widened size would reach the top of the address space, it replaces the range commands with a single whole-cache command.

The queue port uses a valid/ready handshake with an extra reject input. A command that is taken while reject is high is offered again, unchanged, until it is accepted cleanly. The line size and the chunk limit are parameters, both given as powers of two. A one-cycle done pulse marks the end of each request.

Top module: `rsplit_top`

## Requirements
- R1: During and right after reset, req_ready is 1, cmd_valid is 0 and done is 0.
- R2: Every range command carries a line-aligned address. The first one is the request start with its low log2(line) bits cleared, and each later one is the previous address plus the previous size, modulo 2^ADDR_W.
- R3: Let D be end minus the aligned start, modulo 2^ADDR_W. The range commands of a request together cover D rounded up to a whole number of lines.
- R4: Each range command's size is the smaller of the bytes still to cover and 2^LIMIT_LG2 minus one line. The size is never zero.
- R5: If D is at least 2^ADDR_W minus one line, the block issues exactly one whole-cache command (scope 1, address 0, size 0) and no range commands.
- R6: After the last range command, or after the whole-cache command, the block issues a sync command (scope 2, address 0, size 0). done is high for exactly the one cycle after that sync is accepted, and req_ready is 1 again in that same cycle.
- R7: If D is 0, the request issues no range command, only the sync.
- R8: A command is accepted only in a cycle with cmd_valid, cmd_ready and no cmd_reject. While it has not been accepted, cmd_valid stays 1 and the address, size and scope do not change.
- R9: A request is taken only when req_ready is 1, and req_ready is 0 whenever cmd_valid is 1. req_valid and the request fields have no effect while req_ready is 0.
- R10: The scope code is 0 for a range, 1 for whole-cache and 2 for sync. Every command of a request carries that request's op unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request is taken this cycle if valid |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | End address of the range (exclusive) |
| req_op | input | OP_W | Operation code, passed through |
| cmd_valid | output | 1 | Command offered to the queue |
| cmd_ready | input | 1 | Queue samples the command this cycle |
| cmd_reject | input | 1 | Registration refused; the same command is offered again |
| cmd_addr | output | ADDR_W | Chunk address (0 for whole-cache and sync) |
| cmd_size | output | ADDR_W | Chunk size in bytes (0 for whole-cache and sync) |
| cmd_op | output | OP_W | Operation code of the current request |
| cmd_scope | output | 2 | 0 range, 1 whole-cache, 2 sync |
| done | output | 1 | One-cycle pulse after the sync is accepted |

## Verification
The assertions take for granted that the queue port never raises cmd_reject without cmd_ready, or at least that such a reject means nothing. They also assume that cmd_ready and cmd_reject are stable from one clock edge to the next. The bench drives both inputs shortly after each rising edge, and drives reject only in phases with random acceptance. Request fields may change freely while the block is busy. The bench does exactly that, pushing junk requests while a request is in flight, to show that they are ignored.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

   typedef enum logic [1:0] {
      SCOPE_RANGE = 2'd0,
      SCOPE_ALL   = 2'd1,
      SCOPE_SYNC  = 2'd2
   } scope_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RANGE = 2'd1,
      ST_ALL   = 2'd2,
      ST_SYNC  = 2'd3
   } state_e;

endpackage

// File: rtl/rsplit_align.sv
module rsplit_align #(
   parameter int ADDR_W   = 32,
   parameter int LINE_LG2 = 6
) (
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] end_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] span_o,
   output logic              whole_o,
   output logic              empty_o
);
   localparam int HI_W = ADDR_W - LINE_LG2;
   localparam logic [ADDR_W-1:0] LOW_MASK = {{HI_W{1'b0}}, {LINE_LG2{1'b1}}};

   logic [ADDR_W-1:0] diff;
   logic [ADDR_W-1:0] padded;

   always_comb begin
      base_o  = start_i & ~LOW_MASK;
      diff    = end_i - base_o;
      // diff >= -line  <=>  every bit above the line offset is set
      whole_o = &diff[ADDR_W-1:LINE_LG2];
      padded  = diff + LOW_MASK;
      span_o  = padded & ~LOW_MASK;
      empty_o = (diff == '0);
   end
endmodule

// File: rtl/rsplit_chunk.sv
module rsplit_chunk #(
   parameter int ADDR_W    = 32,
   parameter int LINE_LG2  = 6,
   parameter int LIMIT_LG2 = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] span_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ADDR_W-1:0] chunk_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] remain;

   generate
      if (LIMIT_LG2 >= ADDR_W) begin : g_uncapped
         // any legal span already fits below the limit
         always_comb chunk_o = remain;
      end else begin : g_capped
         localparam logic [ADDR_W-1:0] CHUNK_MAX =
            ADDR_W'((64'd1 << LIMIT_LG2) - (64'd1 << LINE_LG2));
         always_comb chunk_o = (remain > CHUNK_MAX) ? CHUNK_MAX : remain;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         remain   <= '0;
      end else if (load_i) begin
         cur_addr <= base_i;
         remain   <= span_i;
      end else if (advance_i) begin
         cur_addr <= cur_addr + chunk_o;
         remain   <= remain - chunk_o;
      end
   end

   always_comb begin
      addr_o = cur_addr;
      last_o = (remain == chunk_o);
   end

   AST_REMAIN_LINE_MULTIPLE: assert property (@(posedge clk) disable iff (!rst_n)
      remain[LINE_LG2-1:0] == '0);  // R3
endmodule

// File: rtl/rsplit_ctrl.sv
module rsplit_ctrl
   import rsplit_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid_i,
   input  logic   whole_i,
   input  logic   empty_i,
   input  logic   last_i,
   input  logic   cmd_ready_i,
   input  logic   cmd_reject_i,
   output logic   req_ready_o,
   output logic   cmd_valid_o,
   output scope_e scope_o,
   output logic   load_o,
   output logic   advance_o,
   output logic   done_o
);
   state_e state, state_nx;
   logic   taken;
   logic   done_nx;

   always_comb begin
      state_nx    = state;
      req_ready_o = 1'b0;
      cmd_valid_o = 1'b0;
      scope_o     = SCOPE_SYNC;
      load_o      = 1'b0;
      advance_o   = 1'b0;
      done_nx     = 1'b0;
      taken       = cmd_ready_i && !cmd_reject_i;
      unique case (state)
         ST_IDLE: begin
            req_ready_o = 1'b1;
            if (req_valid_i) begin
               load_o = 1'b1;
               if (whole_i)      state_nx = ST_ALL;
               else if (empty_i) state_nx = ST_SYNC;
               else              state_nx = ST_RANGE;
            end
         end
         ST_RANGE: begin
            cmd_valid_o = 1'b1;
            scope_o     = SCOPE_RANGE;
            if (taken) begin
               advance_o = 1'b1;
               if (last_i) state_nx = ST_SYNC;
            end
         end
         ST_ALL: begin
            cmd_valid_o = 1'b1;
            scope_o     = SCOPE_ALL;
            if (taken) state_nx = ST_SYNC;
         end
         ST_SYNC: begin
            cmd_valid_o = 1'b1;
            scope_o     = SCOPE_SYNC;
            if (taken) begin
               state_nx = ST_IDLE;
               done_nx  = 1'b1;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done_o <= 1'b0;
      end else begin
         state  <= state_nx;
         done_o <= done_nx;
      end
   end

   AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready_o, cmd_valid_o}));  // R9
   AST_DONE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cmd_valid_o && scope_o == SCOPE_SYNC && cmd_ready_i && !cmd_reject_i));  // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);  // R6
endmodule

// File: rtl/rsplit_top.sv
module rsplit_top
   import rsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_LG2  = 6,
   parameter int LIMIT_LG2 = 22,
   parameter int OP_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   input  logic [OP_W-1:0]   req_op,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   input  logic              cmd_reject,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [ADDR_W-1:0] cmd_size,
   output logic [OP_W-1:0]   cmd_op,
   output logic [1:0]        cmd_scope,
   output logic              done
);
   localparam logic [ADDR_W-1:0] LINE_LOW = ADDR_W'((64'd1 << LINE_LG2) - 64'd1);
   localparam int CAP_LG2 = (LIMIT_LG2 < ADDR_W) ? LIMIT_LG2 : ADDR_W;
   localparam logic [ADDR_W:0] SIZE_CAP =
      (ADDR_W+1)'((65'd1 << CAP_LG2) - (65'd1 << LINE_LG2));

   generate
      if (LINE_LG2 < 1 || LINE_LG2 >= ADDR_W) begin : g_bad_line
         $error("rsplit_top: LINE_LG2 must lie in 1..ADDR_W-1");
      end
      if (LIMIT_LG2 <= LINE_LG2) begin : g_bad_limit
         $error("rsplit_top: LIMIT_LG2 must exceed LINE_LG2");
      end
      if (ADDR_W > 63) begin : g_bad_width
         $error("rsplit_top: ADDR_W above 63 is not supported");
      end
   endgenerate

   logic [ADDR_W-1:0] al_base, al_span;
   logic              al_whole, al_empty;
   logic [ADDR_W-1:0] ch_addr, ch_size;
   logic              ch_last;
   logic              load, advance;
   scope_e            scope;
   logic [OP_W-1:0]   op_q;

   rsplit_align #(.ADDR_W(ADDR_W), .LINE_LG2(LINE_LG2)) u_align (
      .start_i (req_start),
      .end_i   (req_end),
      .base_o  (al_base),
      .span_o  (al_span),
      .whole_o (al_whole),
      .empty_o (al_empty)
   );

   rsplit_chunk #(.ADDR_W(ADDR_W), .LINE_LG2(LINE_LG2), .LIMIT_LG2(LIMIT_LG2)) u_chunk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .base_i    (al_base),
      .span_i    (al_span),
      .advance_i (advance),
      .addr_o    (ch_addr),
      .chunk_o   (ch_size),
      .last_o    (ch_last)
   );

   rsplit_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .whole_i      (al_whole),
      .empty_i      (al_empty),
      .last_i       (ch_last),
      .cmd_ready_i  (cmd_ready),
      .cmd_reject_i (cmd_reject),
      .req_ready_o  (req_ready),
      .cmd_valid_o  (cmd_valid),
      .scope_o      (scope),
      .load_o       (load),
      .advance_o    (advance),
      .done_o       (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    op_q <= '0;
      else if (load) op_q <= req_op;
   end

   always_comb begin
      cmd_op    = op_q;
      cmd_scope = scope;
      cmd_addr  = (scope == SCOPE_RANGE) ? ch_addr : '0;
      cmd_size  = (scope == SCOPE_RANGE) ? ch_size : '0;
   end

   AST_HOLD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_scope)));  // R8
   AST_RETRY_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_reject) |=>
         (cmd_valid && $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_scope)));  // R8
   AST_CHUNK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_scope == 2'd0) |->
         (cmd_size != '0 && {1'b0, cmd_size} <= SIZE_CAP));  // R4
   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_scope == 2'd0) |->
         ((cmd_addr & LINE_LOW) == '0 && (cmd_size & LINE_LOW) == '0));  // R2
   AST_NEXT_CHUNK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_scope == 2'd0 && cmd_ready && !cmd_reject) |=>
         (cmd_scope != 2'd0 || cmd_addr == $past(cmd_addr) + $past(cmd_size)));  // R2
   AST_OP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && $past(cmd_valid)) |-> $stable(cmd_op));  // R10
   AST_SCOPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_scope != 2'd3);  // R10
   AST_WHOLE_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_scope != 2'd0) |-> (cmd_addr == '0 && cmd_size == '0));  // R5
endmodule

// File: tb/rsplit_top_test.sv
module rsplit_top_test;
   localparam int AW = 16;
   localparam int LL = 4;
   localparam int LIM = 6;
   localparam int LINE = 1 << LL;
   localparam int CMAX = (1 << LIM) - LINE;
   localparam int AMASK = (1 << AW) - 1;

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] s;
      logic [1:0]  k;
   } ecmd_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_start = '0;
   logic [AW-1:0] req_end = '0;
   logic [1:0]    req_op = '0;
   logic          cmd_valid;
   logic          cmd_ready = 1'b1;
   logic          cmd_reject = 1'b0;
   logic [AW-1:0] cmd_addr, cmd_size;
   logic [1:0]    cmd_op;
   logic [1:0]    cmd_scope;
   logic          done;

   int     vectors = 0;
   int     fails = 0;
   int     cycles = 0;
   bit     rand_ready = 0;
   bit     rand_reject = 0;
   bit     hold_off = 0;
   ecmd_t  q[$];
   logic [1:0] exp_op = '0;
   bit     exp_done = 0;
   int     range_bytes = 0;
   int     range_cnt = 0;
   int     all_cnt = 0;
   int     sync_cnt = 0;
   int     reject_cnt = 0;

   always #4 clk = ~clk;

   rsplit_top #(.ADDR_W(AW), .LINE_LG2(LL), .LIMIT_LG2(LIM), .OP_W(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_start(req_start), .req_end(req_end), .req_op(req_op),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_reject(cmd_reject),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_op(cmd_op),
      .cmd_scope(cmd_scope), .done(done)
   );

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cycles, got, exp);
      end
   endtask

   // behavioural reference: expected command list per request
   task automatic expand(input int s, input int e);
      int base, d, span, a, c;
      base = s & ~(LINE - 1);
      d = (e - base) & AMASK;
      if (d >= (1 << AW) - LINE) begin
         q.push_back('{a: 16'h0, s: 16'h0, k: 2'd1});
      end else begin
         span = (d + LINE - 1) & ~(LINE - 1);
         a = base;
         while (span > 0) begin
            c = (span < CMAX) ? span : CMAX;
            q.push_back('{a: 16'(a), s: 16'(c), k: 2'd0});
            a = (a + c) & AMASK;
            span -= c;
         end
      end
      q.push_back('{a: 16'h0, s: 16'h0, k: 2'd2});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         q.delete();
         exp_done <= 0;
      end else begin
         exp_done <= 0;
         if (q.size() == 0) begin
            if (req_valid) begin
               expand(int'(req_start), int'(req_end));
               exp_op <= req_op;
            end
         end else if (cmd_ready && !cmd_reject) begin
            void'(q.pop_front());
            if (q.size() == 0) exp_done <= 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 req_ready", int'(req_ready), int'(q.size() == 0));
         chk("R8 cmd_valid", int'(cmd_valid), int'(q.size() != 0));
         chk("R6 done", int'(done), int'(exp_done));
         if (q.size() != 0 && cmd_valid) begin
            chk("R2 cmd_addr", int'(cmd_addr), int'(q[0].a));
            chk("R4 cmd_size", int'(cmd_size), int'(q[0].s));
            chk("R10 cmd_scope", int'(cmd_scope), int'(q[0].k));
            chk("R10 cmd_op", int'(cmd_op), int'(exp_op));
         end
         if (cmd_valid && cmd_ready) begin
            if (cmd_reject) reject_cnt++;
            else if (cmd_scope == 2'd0) begin range_bytes += int'(cmd_size); range_cnt++; end
            else if (cmd_scope == 2'd1) all_cnt++;
            else sync_cnt++;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (hold_off) cmd_ready = 1'b0;
         else cmd_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
         cmd_reject = (rand_reject && cmd_ready) ? ($urandom % 4 == 0) : 1'b0;
      end
   end

   task automatic clear_counts();
      range_bytes = 0; range_cnt = 0; all_cnt = 0; sync_cnt = 0;
   endtask

   task automatic run_req(input int s, input int e, input logic [1:0] op, input bit junk);
      @(posedge clk); #1;
      req_start = 16'(s); req_end = 16'(e); req_op = op; req_valid = 1'b1;
      do @(posedge clk); while (!req_ready);
      #1;
      if (junk) begin
         hold_off = 1;
         for (int i = 0; i < 6; i++) begin
            req_start = 16'($urandom); req_end = 16'($urandom); req_op = 2'($urandom);
            @(posedge clk); #1;
         end
         hold_off = 0;
      end
      req_valid = 1'b0;
      while (q.size() != 0) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 req_ready in reset", int'(req_ready), 1);
      chk("R1 cmd_valid in reset", int'(cmd_valid), 0);
      chk("R1 done in reset", int'(done), 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_ready after reset", int'(req_ready), 1);
      chk("R1 cmd_valid after reset", int'(cmd_valid), 0);

      clear_counts(); run_req(16'h0100, 16'h0120, 2'd0, 0);
      chk("R3 aligned bytes", range_bytes, 32);
      chk("R6 one sync", sync_cnt, 1);

      clear_counts(); run_req(16'h0105, 16'h0131, 2'd1, 0);
      chk("R3 unaligned bytes", range_bytes, 64);
      chk("R4 unaligned chunk count", range_cnt, 2);

      clear_counts(); run_req(16'h1000, 16'h1200, 2'd2, 0);
      chk("R4 long chunk count", range_cnt, 11);
      chk("R3 long bytes", range_bytes, 512);

      clear_counts(); run_req(16'h0205, 16'h0200, 2'd1, 0);
      chk("R7 zero range chunks", range_cnt, 0);
      chk("R7 zero sync count", sync_cnt, 1);

      clear_counts(); run_req(16'h0010, 16'h0000, 2'd2, 0);
      chk("R5 whole-cache at boundary", all_cnt, 1);
      chk("R5 no range on fallback", range_cnt, 0);

      clear_counts(); run_req(16'h001f, 16'h000f, 2'd0, 0);
      chk("R5 whole-cache top", all_cnt, 1);

      clear_counts(); run_req(16'h0010, 16'hffff, 2'd1, 0);
      chk("R5 just below fallback", all_cnt, 0);
      chk("R3 just below fallback bytes", range_bytes, 16'hfff0);

      clear_counts(); run_req(16'h8000, 16'h0100, 2'd0, 0);
      chk("R3 wrapped range bytes", range_bytes, 16'h8100);

      rand_ready = 1; rand_reject = 1;
      clear_counts(); run_req(16'h2003, 16'h2191, 2'd2, 0);
      chk("R8 bytes under rejects", range_bytes, 16'h1a0);
      chk("R8 rejects occurred", int'(reject_cnt > 0), 1);

      rand_reject = 0;
      clear_counts(); run_req(16'h3000, 16'h3100, 2'd1, 1);
      chk("R9 junk ignored bytes", range_bytes, 256);

      rand_reject = 1;
      for (int n = 0; n < 25; n++) begin
         int s0, l0;
         s0 = $urandom % 65536;
         l0 = $urandom % 400;
         run_req(s0, (s0 + l0) & AMASK, 2'($urandom), 0);
      end
      rand_ready = 0; rand_reject = 0;

      // back-to-back: request waiting while done pulses
      @(posedge clk); #1;
      req_start = 16'h0400; req_end = 16'h0410; req_op = 2'd3; req_valid = 1'b1;
      repeat (2) begin
         do @(posedge clk); while (!req_ready);
      end
      #1; req_valid = 1'b0;
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      while (cycles < 150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule